// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

This block is a small set-associative data cache for one core that can run a group of accesses as a hardware transaction. Each line stores one data word and carries four flags: valid, dirty, a speculative-read marker and a speculative-write marker. The core sends one request per cycle: load, store, begin, end, explicit abort, or a signal that it hit an operation not allowed inside a transaction. A second agent sends snoop requests, either a read or an invalidate. A simple word-wide backing memory port covers misses and write-backs.

Inside a transaction, loads mark their line as read and stores stay only in their line with the write marker set. When the outermost end arrives, all markers clear in one cycle and the stored words become ordinary dirty data that anyone can see. A conflicting snoop, a set with every way marked, an explicit abort or a forbidden operation aborts instead. On abort every write-marked line is dropped in one cycle and a 2-bit reason is reported.

The controller has two states. `ST_PLAIN` is the non-transactional state and `ST_TXN` is the transactional state. There are five transitions:
- **outer begin**: `ST_PLAIN` to `ST_TXN`, with depth set to 1.
- **nested begin**: stays in `ST_TXN` and adds one to the depth.
- **inner end**: stays in `ST_TXN` and subtracts one from the depth.
- **commit**: an end at depth 1, going to `ST_PLAIN`.
- **abort**: `ST_TXN` to `ST_PLAIN`, from any cause.

Top module: `tcc_cache`

## Requirements
- R1: After reset the block is out of transactional mode, `tx_abort` is low, and neither `load_valid` nor `snoop_rsp_valid` is asserted.
- R2: Op code 3 (begin) enters transactional mode, and `in_tx` goes high the cycle after. A begin issued inside a transaction only raises the nesting depth. Only the end (op code 4) that brings the depth back to zero leaves the mode.
- R3: Once a transactional load (op code 1) has touched a line, a snooped invalidate to that address aborts the transaction. `tx_abort` pulses the cycle after the snoop, with `abort_code` 00 (conflict).
- R4: A transactional store (op code 2) never writes its value to the memory port. A snooped read of a write-marked address aborts with code 00, and the snoop response carries `snoop_rsp_hit` low.
- R5: The commit makes every buffered store visible at once: later loads return the stored values and a snooped read supplies them. The commit also clears all markers.
- R6: After any abort, `in_tx` is low in the same cycle as the `tx_abort` pulse, and loads return the values from before the transaction.
- R7: When a transactional access misses in a set where every way carries a marker, the transaction aborts with code 01 (capacity). An unmarked way in the set is evicted instead, and no abort happens.
- R8: Op code 5 inside a transaction aborts with code 10. Op code 6 inside a transaction aborts with code 11. Outside a transaction both have no effect.
- R9: A snooped read of a line that carries only the read marker does not abort, and it supplies the line's data.
- R10: Outside a transaction the cache is write-back. A snooped invalidate of a dirty line writes the word to memory before dropping the line, and memory always ends up holding the last committed value.
- R11: While `snoop_valid` is high, `core_ready` is low and the core request in that cycle has no effect.
- R12: A begin at the maximum nesting depth (`MAX_NEST`, default 3) aborts with code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present |
| core_op | input | 3 | 0 nop, 1 load, 2 store, 3 begin, 4 end, 5 abort, 6 forbidden, 7 nop |
| core_addr | input | ADDR_W | Word address of a load or store |
| core_wdata | input | DATA_W | Store data |
| core_ready | output | 1 | Core request accepted this cycle |
| load_valid | output | 1 | Load result valid, one cycle after the request |
| load_data | output | DATA_W | Load result |
| in_tx | output | 1 | Transactional mode |
| tx_abort | output | 1 | One-cycle abort pulse |
| abort_code | output | 2 | Reason of the last abort |
| snoop_valid | input | 1 | Snoop request present |
| snoop_inv | input | 1 | 1 invalidate, 0 read |
| snoop_addr | input | ADDR_W | Snooped word address |
| snoop_rsp_valid | output | 1 | Response to a snooped read |
| snoop_rsp_hit | output | 1 | The cache supplied the data |
| snoop_rsp_data | output | DATA_W | Supplied data |
| mem_raddr | output | ADDR_W | Fill address |
| mem_rdata | input | DATA_W | Fill data, same cycle |
| mem_we | output | 1 | Write-back strobe |
| mem_waddr | output | ADDR_W | Write-back address |
| mem_wdata | output | DATA_W | Write-back data |

## Verification
A wrong marker bit shows up at the ports within one cycle of the next snoop to that address. A lost read marker shows as a missing `tx_abort` pulse. A stray write marker shows as an abort, or as a withheld snoop hit on a committed line. A missed bulk clear or discard appears at the next load of an affected address, as a stale or speculative value in `load_data`. A missed write-back appears in the memory contents as soon as the line is invalidated. The nesting counter becomes visible only at the end or begin that should have changed mode.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_BEGIN  = 3'd3,
        OP_END    = 3'd4,
        OP_ABORT  = 3'd5,
        OP_FORBID = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WHY_CONFLICT  = 2'b00,
        WHY_CAPACITY  = 2'b01,
        WHY_EXPLICIT  = 2'b10,
        WHY_FORBIDDEN = 2'b11
    } why_e;

    typedef enum logic {
        ST_PLAIN = 1'b0,
        ST_TXN   = 1'b1
    } txst_e;
endpackage

// File: rtl/tcc_lookup.sv
module tcc_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 4,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_valid,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = set_valid[g] && (set_tags[g] == tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/tcc_victim.sv
module tcc_victim #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic [WAYS-1:0]  set_valid,
    input  logic [WAYS-1:0]  set_marked,
    input  logic [WAY_W-1:0] start,
    output logic [WAY_W-1:0] vic_way,
    output logic             vic_ok
);
    logic             found_inv, found_un;
    logic [WAY_W-1:0] inv_way, un_way, w;

    always_comb begin
        found_inv = 1'b0;
        found_un  = 1'b0;
        inv_way   = '0;
        un_way    = '0;
        w         = '0;
        for (int k = 0; k < WAYS; k++) begin
            w = start + WAY_W'(k);
            if (!set_valid[w] && !found_inv) begin
                found_inv = 1'b1;
                inv_way   = w;
            end
            if (!set_marked[w] && !found_un) begin
                found_un = 1'b1;
                un_way   = w;
            end
        end
        vic_way = found_inv ? inv_way : un_way;
        vic_ok  = found_inv | found_un;
    end
endmodule

// File: rtl/tcc_txctl.sv
module tcc_txctl
    import tcc_pkg::*;
#(
    parameter int MAX_NEST = 3,
    parameter int DEP_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_begin,
    input  logic             cmd_end,
    input  logic             cmd_xabort,
    input  logic             cmd_forbid,
    input  logic             conflict,
    input  logic             capacity,
    output logic             in_tx,
    output logic [DEP_W-1:0] tx_depth,
    output logic             commit_now,
    output logic             abort_now,
    output logic             tx_abort,
    output logic [1:0]       abort_code
);
    localparam logic [DEP_W-1:0] DEP_MAX = DEP_W'(MAX_NEST);
    localparam logic [DEP_W-1:0] DEP_ONE = DEP_W'(1);

    txst_e            state_q, state_n;
    logic [DEP_W-1:0] depth_q, depth_n;
    why_e             why;

    always_comb begin
        state_n    = state_q;
        depth_n    = depth_q;
        commit_now = 1'b0;
        abort_now  = 1'b0;
        why        = WHY_CONFLICT;
        unique case (state_q)
            ST_PLAIN: begin
                if (cmd_begin) begin
                    state_n = ST_TXN;
                    depth_n = DEP_ONE;
                end
            end
            ST_TXN: begin
                if (conflict) begin
                    abort_now = 1'b1;
                    why       = WHY_CONFLICT;
                end else if (capacity) begin
                    abort_now = 1'b1;
                    why       = WHY_CAPACITY;
                end else if (cmd_xabort) begin
                    abort_now = 1'b1;
                    why       = WHY_EXPLICIT;
                end else if (cmd_forbid || (cmd_begin && depth_q == DEP_MAX)) begin
                    abort_now = 1'b1;
                    why       = WHY_FORBIDDEN;
                end else if (cmd_begin) begin
                    depth_n = depth_q + DEP_ONE;
                end else if (cmd_end) begin
                    if (depth_q == DEP_ONE) begin
                        commit_now = 1'b1;
                        state_n    = ST_PLAIN;
                        depth_n    = '0;
                    end else begin
                        depth_n = depth_q - DEP_ONE;
                    end
                end
                if (abort_now) begin
                    state_n = ST_PLAIN;
                    depth_n = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_PLAIN;
            depth_q    <= '0;
            tx_abort   <= 1'b0;
            abort_code <= 2'b00;
        end else begin
            state_q  <= state_n;
            depth_q  <= depth_n;
            tx_abort <= abort_now;
            if (abort_now) abort_code <= why;
        end
    end

    always_comb begin
        in_tx    = (state_q == ST_TXN);
        tx_depth = depth_q;
    end
endmodule

// File: rtl/tcc_cache.sv
module tcc_cache
    import tcc_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int SETS     = 4,
    parameter int WAYS     = 2,
    parameter int MAX_NEST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [2:0]        core_op,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              load_valid,
    output logic [DATA_W-1:0] load_data,
    output logic              in_tx,
    output logic              tx_abort,
    output logic [1:0]        abort_code,
    input  logic              snoop_valid,
    input  logic              snoop_inv,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_rsp_valid,
    output logic              snoop_rsp_hit,
    output logic [DATA_W-1:0] snoop_rsp_data,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam int DEP_W = $clog2(MAX_NEST + 1);

    typedef logic [SETS-1:0][WAYS-1:0] flags_t;

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_n  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];
    logic [DATA_W-1:0] data_n [SETS][WAYS];
    logic [WAY_W-1:0]  ptr_q  [SETS];
    logic [WAY_W-1:0]  ptr_n  [SETS];
    flags_t val_q, dty_q, rmk_q, wmk_q;
    flags_t val_a, dty_a, rmk_a, wmk_a;
    flags_t val_n, dty_n, rmk_n, wmk_n;

    logic [ADDR_W-1:0] acc_addr;
    logic [IDX_W-1:0]  acc_idx;
    logic [TAG_W-1:0]  acc_tag;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic              hit, vic_ok;
    logic [WAY_W-1:0]  hit_way, vic_way, tgt;
    op_e               op;
    logic              core_go, is_ld, is_st;
    logic              conflict, capacity, commit_now, abort_now;
    logic [DEP_W-1:0]  tx_depth;
    logic              ld_v_d, sr_v_d, sr_h_d;
    logic [DATA_W-1:0] ld_d_d, sr_d_d;

    assign op         = op_e'(core_op);
    assign core_ready = !snoop_valid;
    assign core_go    = core_valid && !snoop_valid;
    assign is_ld      = core_go && (op == OP_LOAD);
    assign is_st      = core_go && (op == OP_STORE);
    assign acc_addr   = snoop_valid ? snoop_addr : core_addr;
    assign acc_idx    = acc_addr[IDX_W-1:0];
    assign acc_tag    = acc_addr[ADDR_W-1:IDX_W];
    assign mem_raddr  = core_addr;

    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[acc_idx][w];
    end

    tcc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
        .set_tags (set_tags),
        .set_valid(val_q[acc_idx]),
        .tag      (acc_tag),
        .hit      (hit),
        .hit_way  (hit_way)
    );

    tcc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .set_valid (val_q[acc_idx]),
        .set_marked(rmk_q[acc_idx] | wmk_q[acc_idx]),
        .start     (ptr_q[acc_idx]),
        .vic_way   (vic_way),
        .vic_ok    (vic_ok)
    );

    tcc_txctl #(.MAX_NEST(MAX_NEST), .DEP_W(DEP_W)) u_txctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_begin (core_go && op == OP_BEGIN),
        .cmd_end   (core_go && op == OP_END),
        .cmd_xabort(core_go && op == OP_ABORT),
        .cmd_forbid(core_go && op == OP_FORBID),
        .conflict  (conflict),
        .capacity  (capacity),
        .in_tx     (in_tx),
        .tx_depth  (tx_depth),
        .commit_now(commit_now),
        .abort_now (abort_now),
        .tx_abort  (tx_abort),
        .abort_code(abort_code)
    );

    // Per-access line update: one snoop or one core access per cycle
    always_comb begin
        tag_n = tag_q;  data_n = data_q;  ptr_n = ptr_q;
        val_a = val_q;  dty_a = dty_q;    rmk_a = rmk_q;  wmk_a = wmk_q;
        mem_we = 1'b0;  mem_waddr = '0;   mem_wdata = '0;
        conflict = 1'b0; capacity = 1'b0;
        ld_v_d = 1'b0;  ld_d_d = '0;
        sr_v_d = 1'b0;  sr_h_d = 1'b0;    sr_d_d = '0;
        tgt = hit ? hit_way : vic_way;
        if (snoop_valid) begin
            sr_v_d = !snoop_inv;
            if (hit) begin
                if (snoop_inv) begin
                    conflict = in_tx && (rmk_q[acc_idx][hit_way] || wmk_q[acc_idx][hit_way]);
                    if (dty_q[acc_idx][hit_way]) begin
                        mem_we    = 1'b1;
                        mem_waddr = acc_addr;
                        mem_wdata = data_q[acc_idx][hit_way];
                    end
                    val_a[acc_idx][hit_way] = 1'b0;
                    dty_a[acc_idx][hit_way] = 1'b0;
                    rmk_a[acc_idx][hit_way] = 1'b0;
                    wmk_a[acc_idx][hit_way] = 1'b0;
                end else begin
                    conflict = in_tx && wmk_q[acc_idx][hit_way];
                    sr_h_d   = !wmk_q[acc_idx][hit_way];
                    sr_d_d   = data_q[acc_idx][hit_way];
                end
            end
        end else if (is_ld || is_st) begin
            if (!hit && in_tx && !vic_ok) begin
                capacity = 1'b1;
            end else begin
                if (!hit) begin
                    if (val_q[acc_idx][tgt] && dty_q[acc_idx][tgt]) begin
                        mem_we    = 1'b1;
                        mem_waddr = {tag_q[acc_idx][tgt], acc_idx};
                        mem_wdata = data_q[acc_idx][tgt];
                    end
                    tag_n[acc_idx][tgt]  = acc_tag;
                    data_n[acc_idx][tgt] = mem_rdata;
                    val_a[acc_idx][tgt]  = 1'b1;
                    dty_a[acc_idx][tgt]  = 1'b0;
                    rmk_a[acc_idx][tgt]  = 1'b0;
                    wmk_a[acc_idx][tgt]  = 1'b0;
                    ptr_n[acc_idx]       = tgt + 1'b1;
                end
                if (is_ld) begin
                    ld_v_d = 1'b1;
                    ld_d_d = hit ? data_q[acc_idx][tgt] : mem_rdata;
                    if (in_tx) rmk_a[acc_idx][tgt] = 1'b1;
                end else begin
                    if (hit && in_tx && dty_q[acc_idx][tgt] && !wmk_q[acc_idx][tgt]) begin
                        mem_we    = 1'b1;
                        mem_waddr = acc_addr;
                        mem_wdata = data_q[acc_idx][tgt];
                        dty_a[acc_idx][tgt] = 1'b0;
                    end
                    data_n[acc_idx][tgt] = core_wdata;
                    if (in_tx) wmk_a[acc_idx][tgt] = 1'b1;
                    else       dty_a[acc_idx][tgt] = 1'b1;
                end
            end
        end
    end

    // Bulk commit / discard across every line in one cycle
    always_comb begin
        val_n = val_a;  dty_n = dty_a;  rmk_n = rmk_a;  wmk_n = wmk_a;
        if (abort_now) begin
            val_n = val_a & ~wmk_a;
            rmk_n = '0;
            wmk_n = '0;
        end else if (commit_now) begin
            dty_n = dty_a | wmk_a;
            rmk_n = '0;
            wmk_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;  dty_q <= '0;  rmk_q <= '0;  wmk_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                ptr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]  <= '0;
                    data_q[s][w] <= '0;
                end
            end
            load_valid      <= 1'b0;
            load_data       <= '0;
            snoop_rsp_valid <= 1'b0;
            snoop_rsp_hit   <= 1'b0;
            snoop_rsp_data  <= '0;
        end else begin
            val_q <= val_n;  dty_q <= dty_n;  rmk_q <= rmk_n;  wmk_q <= wmk_n;
            tag_q  <= tag_n;
            data_q <= data_n;
            ptr_q  <= ptr_n;
            load_valid      <= ld_v_d;
            load_data       <= ld_d_d;
            snoop_rsp_valid <= sr_v_d;
            snoop_rsp_hit   <= sr_h_d;
            snoop_rsp_data  <= sr_d_d;
        end
    end
endmodule

// File: rtl/tcc_cache_chk.sv
module tcc_cache_chk #(
    parameter int DEP_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_valid,
    input logic             core_ready,
    input logic [2:0]       core_op,
    input logic             snoop_valid,
    input logic             in_tx,
    input logic [DEP_W-1:0] tx_depth,
    input logic             tx_abort,
    input logic [1:0]       abort_code,
    input logic             load_valid
);
    assert_abort_exits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !in_tx);

    assert_begin_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_tx) |-> $past(core_valid && core_ready && core_op == 3'd3));

    assert_depth_matches_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_tx == (tx_depth != '0));

    assert_conflict_from_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort && abort_code == 2'b00) |-> $past(snoop_valid));

    assert_capacity_from_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort && abort_code == 2'b01)
            |-> $past(core_valid && core_ready && (core_op == 3'd1 || core_op == 3'd2)));

    assert_explicit_from_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_abort && abort_code == 2'b10) |-> $past(core_valid && core_ready && core_op == 3'd5));

    assert_stalled_no_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ready |=> !load_valid);
endmodule

bind tcc_cache tcc_cache_chk #(.DEP_W(DEP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_valid (core_valid),
    .core_ready (core_ready),
    .core_op    (core_op),
    .snoop_valid(snoop_valid),
    .in_tx      (in_tx),
    .tx_depth   (tx_depth),
    .tx_abort   (tx_abort),
    .abort_code (abort_code),
    .load_valid (load_valid)
);

// File: tb/test_tcc_cache.sv
module test_tcc_cache;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;
    localparam int MAXN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_valid = 1'b0;
    logic [2:0] core_op = 3'd0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic snoop_valid = 1'b0, snoop_inv = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic core_ready, load_valid, in_tx, tx_abort, snoop_rsp_valid, snoop_rsp_hit, mem_we;
    logic [DW-1:0] load_data, snoop_rsp_data, mem_rdata, mem_wdata;
    logic [1:0] abort_code;
    logic [AW-1:0] mem_raddr, mem_waddr;

    logic [DW-1:0] bmem [NW];
    logic [DW-1:0] cmem [NW];
    logic [DW-1:0] sbuf [NW];
    bit swr [NW];
    bit srd [NW];
    bit m_tx;
    int m_dep;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tcc_cache i_tcc_cache (
        .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
        .load_valid(load_valid), .load_data(load_data), .in_tx(in_tx),
        .tx_abort(tx_abort), .abort_code(abort_code), .snoop_valid(snoop_valid),
        .snoop_inv(snoop_inv), .snoop_addr(snoop_addr), .snoop_rsp_valid(snoop_rsp_valid),
        .snoop_rsp_hit(snoop_rsp_hit), .snoop_rsp_data(snoop_rsp_data),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    assign mem_rdata = bmem[mem_raddr];
    always @(posedge clk) if (mem_we) bmem[mem_waddr] <= mem_wdata;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic void spec_drop();
        for (int a = 0; a < NW; a++) begin swr[a] = 0; srd[a] = 0; end
        m_tx = 0; m_dep = 0;
    endfunction

    function automatic void spec_commit();
        for (int a = 0; a < NW; a++) if (swr[a]) cmem[a] = sbuf[a];
        spec_drop();
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One core request, predicted by the bench model, checked one cycle later
    task automatic core_step(input logic [2:0] op, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input bit exp_cap, input string rq);
        bit e_ab = 0, e_lv = 0;
        logic [1:0] e_code = 2'b00;
        logic [DW-1:0] e_ld = '0;
        case (op)
            3'd1: if (m_tx && exp_cap) begin e_ab = 1; e_code = 2'b01; end
                  else begin
                      e_lv = 1; e_ld = (m_tx && swr[a]) ? sbuf[a] : cmem[a];
                      if (m_tx) srd[a] = 1;
                  end
            3'd2: if (m_tx && exp_cap) begin e_ab = 1; e_code = 2'b01; end
                  else if (m_tx) begin sbuf[a] = wd; swr[a] = 1; end
                  else cmem[a] = wd;
            3'd3: if (!m_tx) begin m_tx = 1; m_dep = 1; end
                  else if (m_dep == MAXN) begin e_ab = 1; e_code = 2'b11; end
                  else m_dep++;
            3'd4: if (m_tx) begin if (m_dep == 1) spec_commit(); else m_dep--; end
            3'd5: if (m_tx) begin e_ab = 1; e_code = 2'b10; end
            3'd6: if (m_tx) begin e_ab = 1; e_code = 2'b11; end
            default: ;
        endcase
        if (e_ab) spec_drop();
        @(negedge clk);
        core_valid = 1; core_op = op; core_addr = a; core_wdata = wd;
        @(posedge clk); #1;
        core_valid = 0;
        chk(tx_abort == e_ab, rq, "tx_abort", 32'(tx_abort), 32'(e_ab));
        if (e_ab) chk(abort_code == e_code, rq, "abort_code", 32'(abort_code), 32'(e_code));
        chk(in_tx == m_tx, rq, "in_tx", 32'(in_tx), 32'(m_tx));
        chk(load_valid == e_lv, rq, "load_valid", 32'(load_valid), 32'(e_lv));
        if (e_lv) chk(load_data == e_ld, rq, "load_data", 32'(load_data), 32'(e_ld));
    endtask

    task automatic snoop_step(input bit inv, input logic [AW-1:0] a,
                              input bit need_hit, input string rq);
        bit cf = m_tx && (inv ? (srd[a] || swr[a]) : swr[a]);
        if (cf) spec_drop();
        @(negedge clk);
        snoop_valid = 1; snoop_inv = inv; snoop_addr = a;
        @(posedge clk); #1;
        snoop_valid = 0;
        chk(tx_abort == cf, rq, "snoop abort", 32'(tx_abort), 32'(cf));
        if (cf) chk(abort_code == 2'b00, rq, "snoop abort_code", 32'(abort_code), 0);
        chk(in_tx == m_tx, rq, "in_tx after snoop", 32'(in_tx), 32'(m_tx));
        chk(snoop_rsp_valid == !inv, rq, "snoop_rsp_valid", 32'(snoop_rsp_valid), 32'(!inv));
        if (!inv && cf) chk(!snoop_rsp_hit, rq, "speculative value supplied", 32'(snoop_rsp_hit), 0);
        if (need_hit) chk(snoop_rsp_hit, rq, "snoop_rsp_hit", 32'(snoop_rsp_hit), 1);
        if (!inv && snoop_rsp_hit)
            chk(snoop_rsp_data == cmem[a], rq, "snoop_rsp_data", 32'(snoop_rsp_data), 32'(cmem[a]));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < NW; a++) begin
            bmem[a] = DW'(a * 3 + 100);
            cmem[a] = DW'(a * 3 + 100);
        end
        spec_drop();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk(!in_tx, "R1", "in_tx", 32'(in_tx), 0);
        chk(!tx_abort, "R1", "tx_abort", 32'(tx_abort), 0);
        chk(!load_valid, "R1", "load_valid", 32'(load_valid), 0);
        chk(!snoop_rsp_valid, "R1", "snoop_rsp_valid", 32'(snoop_rsp_valid), 0);

        // R10 write-back on invalidate of a dirty line
        core_step(3'd2, 6'd20, 16'hA5A5, 0, "R10");
        snoop_step(1, 6'd20, 0, "R10");
        chk(bmem[20] == 16'hA5A5, "R10", "memory after invalidate", 32'(bmem[20]), 32'hA5A5);
        core_step(3'd1, 6'd20, 0, 0, "R10");

        // R2 nesting, R5 commit
        core_step(3'd3, 0, 0, 0, "R2");
        core_step(3'd3, 0, 0, 0, "R2");
        core_step(3'd2, 6'd1, 16'h1111, 0, "R2");
        core_step(3'd4, 0, 0, 0, "R2");
        core_step(3'd4, 0, 0, 0, "R5");
        core_step(3'd1, 6'd1, 0, 0, "R5");
        snoop_step(0, 6'd1, 1, "R5");

        // R3 read-set conflict
        core_step(3'd3, 0, 0, 0, "R3");
        core_step(3'd1, 6'd2, 0, 0, "R3");
        snoop_step(1, 6'd2, 0, "R3");

        // R4 write-set isolation, R6 discard
        core_step(3'd3, 0, 0, 0, "R4");
        core_step(3'd2, 6'd3, 16'h3333, 0, "R4");
        chk(bmem[3] != 16'h3333, "R4", "speculative value in memory", 32'(bmem[3]), 32'(cmem[3]));
        snoop_step(0, 6'd3, 0, "R4");
        core_step(3'd1, 6'd3, 0, 0, "R6");

        // R9 read-only marked line supplied
        core_step(3'd3, 0, 0, 0, "R9");
        core_step(3'd1, 6'd5, 0, 0, "R9");
        snoop_step(0, 6'd5, 1, "R9");
        core_step(3'd4, 0, 0, 0, "R9");

        // R8 explicit and forbidden
        core_step(3'd5, 0, 0, 0, "R8");
        core_step(3'd6, 0, 0, 0, "R8");
        core_step(3'd3, 0, 0, 0, "R8");
        core_step(3'd5, 0, 0, 0, "R8");
        core_step(3'd3, 0, 0, 0, "R8");
        core_step(3'd6, 0, 0, 0, "R8");

        // R12 nesting limit
        for (int i = 0; i < MAXN; i++) core_step(3'd3, 0, 0, 0, "R12");
        core_step(3'd3, 0, 0, 0, "R12");

        // R7 capacity with loads, then stores
        core_step(3'd1, 6'd6, 0, 0, "R7");
        core_step(3'd1, 6'd10, 0, 0, "R7");
        core_step(3'd3, 0, 0, 0, "R7");
        core_step(3'd1, 6'd14, 0, 0, "R7");
        core_step(3'd1, 6'd18, 0, 0, "R7");
        core_step(3'd1, 6'd22, 0, 1, "R7");
        core_step(3'd3, 0, 0, 0, "R7");
        core_step(3'd2, 6'd26, 16'h2626, 0, "R7");
        core_step(3'd2, 6'd30, 16'h3030, 0, "R7");
        core_step(3'd2, 6'd34, 16'h3434, 1, "R7");
        core_step(3'd1, 6'd26, 0, 0, "R6");
        core_step(3'd1, 6'd30, 0, 0, "R6");

        // R11 snoop has priority, core request dropped
        @(negedge clk);
        core_valid = 1; core_op = 3'd2; core_addr = 6'd9; core_wdata = 16'hBEEF;
        snoop_valid = 1; snoop_inv = 0; snoop_addr = 6'd7;
        #1;
        chk(!core_ready, "R11", "core_ready", 32'(core_ready), 0);
        @(posedge clk); #1;
        core_valid = 0; snoop_valid = 0;
        core_step(3'd1, 6'd9, 0, 0, "R11");

        // Random phase on two tags per set: no capacity pressure
        for (int n = 0; n < 1500; n++) begin
            int r = int'($urandom % 16);
            logic [AW-1:0] a = AW'($urandom % 8);
            logic [DW-1:0] d = DW'($urandom);
            if (r < 4)       core_step(3'd1, a, 0, 0, "R5");
            else if (r < 8)  core_step(3'd2, a, d, 0, "R6");
            else if (r < 10) core_step(3'd3, 0, 0, 0, "R2");
            else if (r < 12) core_step(3'd4, 0, 0, 0, "R2");
            else if (r == 12) begin
                if ($urandom % 4 == 0) core_step(3'd5, 0, 0, 0, "R8");
                else core_step(3'd1, a, 0, 0, "R9");
            end
            else snoop_step(r[0], a, 0, r[0] ? "R3" : "R4");
        end

        // Final consistency sweep
        if (m_tx) core_step(3'd5, 0, 0, 0, "R8");
        for (int a = 0; a < 8; a++) begin
            core_step(3'd1, AW'(a), 0, 0, "R10");
            snoop_step(1, AW'(a), 0, "R10");
            chk(bmem[a] == cmem[a], "R10", "memory holds committed value", 32'(bmem[a]), 32'(cmem[a]));
        end
        finish_run();
    end
endmodule